// File: doc/BRIEF.md
# PLL Unlock Detector with Stretched Indication

This block watches the phase-error pulse coming out of a PLL phase comparator and decides whether the loop has lost lock. A 2-bit mode field picks one of three behaviours. The detector can be switched off. It can forward the raw error pulse as the unlock signal. It can also run as a width filter: only an error pulse that outlasts a window of about 6.67 µs counts as unlock, and the unlock flag is then held for between one and two milliseconds.

The block produces three outputs. The first is an unlock flag, high while unlocked. The second is the inverse of that flag, for use as a serial status bit that reads 1 when locked and 0 when unlocked. The third is an enable flag that tells the pin driver whether the detector output is in use. A pin driver that sees the enable flag high pulls its pin low while unlock is high, and leaves the pin open otherwise. All timing is counted in system clock cycles. `WIDE_TICKS` is the window length and `MS_TICKS` is the stretch period.

Top module: `unlock_det`

## Requirements
- R1: While `rst_ni` is low, `unlock_o` is 0 and `lock_bit_o` is 1, even with mode 2'b10 and `perr_i` high.
- R2: With mode 2'b00 the detector is stopped. `active_o` is 0, `unlock_o` is 0 and `lock_bit_o` is 1, whatever `perr_i` does.
- R3: With mode 2'b01, `active_o` is 1 and `unlock_o` equals `perr_i` in the same cycle, with no register in between.
- R4: In modes 2'b10 and 2'b11, bit 0 of the mode field has no effect. `unlock_o` rises at the clock edge that samples the (WIDE_TICKS+1)-th consecutive high cycle of `perr_i`. A pulse of WIDE_TICKS cycles or fewer never sets it.
- R5: Pulse width is measured per pulse. One low sample of `perr_i` restarts the measurement, so short pulses never add up to a qualifying width.
- R6: A free-running tick fires at every clock edge whose count since reset release is a multiple of MS_TICKS. In the wide modes, `unlock_o` clears at the HOLD_TICKS-th tick edge that comes strictly after the last edge at which the error still qualified. With the default HOLD_TICKS=2, the flag therefore lasts more than MS_TICKS and at most 2*MS_TICKS cycles after that edge.
- R7: A new qualifying error during the hold restarts the release count from zero.
- R8: While the mode is not 2'b1x, the hold and the width count are cleared. Entering a wide mode therefore starts with `unlock_o` at 0.
- R9: `lock_bit_o` is always the inverse of `unlock_o`. `active_o` is 1 exactly when the mode is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| perr_i | input | 1 | Phase-error pulse, high while an error is present, synchronous to clk_i |
| mode_i | input | 2 | 00 stopped, 01 pass-through, 1x width filter with stretch |
| unlock_o | output | 1 | Unlock indication, high while unlocked |
| active_o | output | 1 | Detector output is in use (mode not 00) |
| lock_bit_o | output | 1 | Serial status bit: 1 locked, 0 unlocked |

## Verification
The bench builds the block with WIDE_TICKS=5 and MS_TICKS=20, and leaves HOLD_TICKS at 2. With these values, pulses of exactly the window length and one cycle longer take only a few cycles. A full stretch, including a restart in the middle of the hold, fits inside about sixty cycles. The bench counts clock edges from reset release, so it can predict on which edge the tick falls and the exact cycle of each release.

// File: rtl/unlock_det_pkg.sv
package unlock_det_pkg;

  typedef enum logic [1:0] {
    UD_OFF    = 2'b00,
    UD_PASS   = 2'b01,
    UD_WIDE   = 2'b10,
    UD_WIDE_B = 2'b11
  } ud_mode_e;

  function automatic logic ud_is_wide(input ud_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/ud_width_meter.sv
// Counts consecutive high samples of the error pulse, saturating at LIMIT.
module ud_width_meter #(
  parameter int LIMIT = 667
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic err_i,
  output logic over_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !err_i)   cnt_q <= '0;
    else if (cnt_q != LIM)      cnt_q <= cnt_q + 1'b1;
  end

  // cnt_q holds earlier high samples; this sample is number LIMIT+1 or later
  assign over_o = err_i && !clr_i && (cnt_q == LIM);

endmodule

// File: rtl/ud_tick_gen.sv
module ud_tick_gen #(
  parameter int PERIOD = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/ud_hold.sv
// Holds the unlock flag until HOLD_TICKS ticks pass with no new qualifying error.
module ud_hold #(
  parameter int HOLD_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic tick_i,
  output logic hold_o
);
  localparam int SW = $clog2(HOLD_TICKS + 1);
  localparam logic [SW-1:0] LAST = SW'(HOLD_TICKS - 1);

  logic          hold_q;
  logic [SW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      seen_q <= '0;
    end else if (clr_i) begin
      hold_q <= 1'b0;
      seen_q <= '0;
    end else if (set_i) begin
      hold_q <= 1'b1;
      seen_q <= '0;
    end else if (hold_q && tick_i) begin
      if (seen_q == LAST) begin
        hold_q <= 1'b0;
        seen_q <= '0;
      end else begin
        seen_q <= seen_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/unlock_det.sv
module unlock_det
  import unlock_det_pkg::*;
#(
  parameter int WIDE_TICKS = 667,
  parameter int MS_TICKS   = 100000,
  parameter int HOLD_TICKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       perr_i,
  input  logic [1:0] mode_i,
  output logic       unlock_o,
  output logic       active_o,
  output logic       lock_bit_o
);
  ud_mode_e mode;
  logic     wide_en;
  logic     qual_err;
  logic     ms_tick;
  logic     hold;

  assign mode    = ud_mode_e'(mode_i);
  assign wide_en = ud_is_wide(mode);

  ud_width_meter #(.LIMIT(WIDE_TICKS)) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!wide_en),
    .err_i (perr_i),
    .over_o(qual_err)
  );

  ud_tick_gen #(.PERIOD(MS_TICKS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(ms_tick)
  );

  ud_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!wide_en),
    .set_i (qual_err),
    .tick_i(ms_tick),
    .hold_o(hold)
  );

  always_comb begin
    unique case (mode)
      UD_OFF:  unlock_o = 1'b0;
      UD_PASS: unlock_o = perr_i && rst_ni;
      default: unlock_o = hold;
    endcase
  end

  assign active_o   = (mode != UD_OFF);
  assign lock_bit_o = !unlock_o;

endmodule

// File: rtl/unlock_det_chk.sv
module unlock_det_chk #(
  parameter int HOLD_TICKS = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       perr_i,
  input logic [1:0] mode_i,
  input logic       unlock_o,
  input logic       active_o,
  input logic       lock_bit_o,
  input logic       ms_tick_i,
  input logic       qual_i
);
  localparam int TW = $clog2(HOLD_TICKS + 1) + 1;
  localparam logic [TW-1:0] FULL = TW'(HOLD_TICKS);

  logic [TW-1:0] ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ticks_q <= '0;
    else if (!mode_i[1] || qual_i)    ticks_q <= '0;
    else if (ms_tick_i && ticks_q != FULL) ticks_q <= ticks_q + 1'b1;
  end

  assert_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |-> (!unlock_o && !active_o && lock_bit_o));

  assert_pass_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |-> (unlock_o == perr_i));

  assert_set_needs_error_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && $past(mode_i[1]) && $rose(unlock_o)) |-> $past(perr_i));

  assert_fall_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && $past(mode_i[1]) && $fell(unlock_o)) |-> $past(ms_tick_i));

  assert_hold_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && ticks_q == FULL) |-> !unlock_o);

endmodule

bind unlock_det unlock_det_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .perr_i    (perr_i),
  .mode_i    (mode_i),
  .unlock_o  (unlock_o),
  .active_o  (active_o),
  .lock_bit_o(lock_bit_o),
  .ms_tick_i (ms_tick),
  .qual_i    (qual_err)
);

// File: tb/tb_unlock_det.sv
`timescale 1ns/1ps
module tb_unlock_det;
  localparam int WIDE = 5;
  localparam int MS   = 20;
  localparam int HOLD = 2;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] width;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'b01, 8'd1,  1'b1},
    '{2'b01, 8'd3,  1'b1},
    '{2'b00, 8'd8,  1'b0},
    '{2'b10, 8'd5,  1'b0},
    '{2'b10, 8'd6,  1'b1},
    '{2'b11, 8'd6,  1'b1},
    '{2'b11, 8'd2,  1'b0},
    '{2'b10, 8'd12, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       perr = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       unlock, active, lock_bit;
  int         ecnt = 0;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;

  unlock_det #(.WIDE_TICKS(WIDE), .MS_TICKS(MS), .HOLD_TICKS(HOLD)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .perr_i    (perr),
    .mode_i    (mode),
    .unlock_o  (unlock),
    .active_o  (active),
    .lock_bit_o(lock_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic idle_then(input logic [1:0] m);
    @(negedge clk); mode = 2'b00; perr = 1'b0;
    @(negedge clk); mode = m;
    @(negedge clk);
  endtask

  task automatic pulse(input int w);
    for (int k = 0; k < w; k++) begin
      perr = 1'b1;
      @(negedge clk);
    end
  endtask

  // Wait for release and return the edge count at which unlock read 0
  task automatic wait_release(output int rel);
    rel = -1;
    for (int k = 0; k < 4 * MS; k++) begin
      if (!unlock) begin rel = ecnt; break; end
      @(negedge clk);
    end
  endtask

  function automatic int release_edge(input int q);
    return (q / MS + 1) * MS + (HOLD - 1) * MS;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int q, q2, t1, rel;
    // R1: reset state with wide mode and error high
    perr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 unlock in reset", unlock, 0);
    chk("R1 lock_bit in reset", lock_bit, 1);
    perr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 unlock after reset", unlock, 0);

    // Table walk: R2, R3, R4, R9
    foreach (VEC[i]) begin
      idle_then(VEC[i].mode);
      pulse(int'(VEC[i].width));
      chk($sformatf("R4/R3/R2 vec%0d unlock", i), unlock, VEC[i].exp);
      chk($sformatf("R9 vec%0d lock_bit", i), lock_bit, !VEC[i].exp);
      chk($sformatf("R9 vec%0d active", i), active, VEC[i].mode != 2'b00);
      perr = 1'b0;
    end

    // R3: falling edge passes through in the same cycle
    idle_then(2'b01);
    perr = 1'b1; #1;
    chk("R3 rise same cycle", unlock, 1);
    perr = 1'b0; #1;
    chk("R3 fall same cycle", unlock, 0);

    // R5: two short pulses split by one low sample do not add up
    idle_then(2'b10);
    pulse(4);
    perr = 1'b0; @(negedge clk);
    pulse(4);
    chk("R5 split pulses", unlock, 0);
    perr = 1'b0;

    // R6: release edge and duration
    idle_then(2'b10);
    pulse(WIDE + 1);
    q = ecnt;
    perr = 1'b0;
    chk("R6 set", unlock, 1);
    wait_release(rel);
    chk("R6 release edge", rel, release_edge(q));
    chk("R6 lower bound", int'((rel - q) > MS), 1);
    chk("R6 upper bound", int'((rel - q) <= 2 * MS), 1);

    // R7: new qualifying error after the first tick restarts the hold
    idle_then(2'b10);
    pulse(WIDE + 1);
    q = ecnt;
    perr = 1'b0;
    t1 = (q / MS + 1) * MS;
    while (ecnt < t1 + 2) @(negedge clk);
    chk("R7 held past first tick", unlock, 1);
    pulse(WIDE + 1);
    q2 = ecnt;
    perr = 1'b0;
    wait_release(rel);
    chk("R7 restarted release", rel, release_edge(q2));

    // R8: leaving the wide mode drops the hold
    idle_then(2'b11);
    pulse(WIDE + 2);
    perr = 1'b0;
    chk("R8 set", unlock, 1);
    mode = 2'b01; #1;
    chk("R8 pass mode shows no hold", unlock, 0);
    @(negedge clk);
    mode = 2'b10; #1;
    chk("R8 hold cleared on return", unlock, 0);
    @(negedge clk);
    chk("R8 stays clear", unlock, 0);

    done = 1'b1;
    finish_run();
  end

endmodule